// File: doc/BRIEF.md
# Prescaled Match Timer

This block is the counting core of a general-purpose timer. A prescale counter divides a stream of count events. Each time the prescaler wraps, a wide timer counter steps by one. The count events are either every clock cycle or chosen edges of one selectable external input. Four compare channels watch the timer counter. When the counter steps away from a channel's compare value, that channel can do any mix of four things: latch an interrupt flag, restart the counter from zero, halt the counter, and change its external output level.

Software reaches everything through a flat register port. A write takes effect on the clock edge that samples it. Reads are combinational from the read address. Each compare channel also has a shadow value. When reload is enabled for that channel, the shadow value replaces the compare value when a compare restarts the counter. This lets the period or the duty cycle of a running waveform change on a cycle boundary without glitches.

Top module: `match_timer`

## Requirements
- R1: The prescale counter counts accepted events from 0 up to the prescale limit and then wraps to 0. The timer counter steps by one exactly on the event that wraps it. A limit of 0 therefore steps the timer on every event. After N events from a cleared state, the timer holds floor(N/(limit+1)) and the prescaler holds N mod (limit+1).
- R2: The low two bits of the mode register select the event source. 0 means every clock cycle. 1, 2 and 3 mean the rising, falling or both edges of the input picked by mode bits [3:2]. Inputs pass through a two-stage synchronizer before edge detection. Edges on inputs that are not selected are never counted.
- R3: Control register bit 0 is the run enable, and counting happens only while it is 1. While control bit 1 is 1, the timer and the prescaler are forced to 0 from the next clock edge.
- R4: Channel n is governed by three bits of the match-control register, starting at bit 3n. Bit 3n enables the interrupt, bit 3n+1 restarts the counter and bit 3n+2 halts it. A channel hits when the timer steps while its value equals the channel's compare value.
- R5: On a hit with the restart bit set, the timer goes to 0 instead of compare+1. The counting period is therefore compare+1 steps.
- R6: On a hit with the halt bit set, the timer keeps the compare value and the run enable clears itself. Counting resumes only after software sets the enable again.
- R7: A hit with the interrupt bit set sets that channel's flag in the flag register (bit n). Writing 1 to bit n clears the flag, and writing 0 leaves it unchanged. `irq` is the OR of all flags.
- R8: A hit changes `match_out[n]` according to the 2-bit action field at bits [2n+1:2n] of the action register: 0 keeps the level, 1 drives it low, 2 drives it high, 3 inverts it. Software can write the levels directly at the level register, and it reads them back as a mask from the same address.
- R9: When a hit restarts the counter, every channel whose bit is set in the reload register copies its shadow value into its compare value.
- R10: Register addresses: 0 control, 1 prescale limit, 2 mode, 3 match control, 4 flags, 5 output actions, 6 output levels, 7 reload enables, 8 timer count (read), 9 prescale count (read), 16+n compare value n, 24+n shadow value n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Read data for rd_addr |
| cnt_in | input | 4 | External inputs that can serve as the count source |
| match_out | output | 4 | External output levels of the compare channels |
| irq | output | 1 | OR of the channel flags |

## Verification
The bench targets several corner cases. The first is the off-by-one in the restart period. A design that restarts when the counter reaches the compare value would come to rest at a different count and would toggle its output one step early. The second is the halt case. A design that stops without clearing the enable, or that steps once more, would read back a count of 4 instead of 3 with the enable still set. The third is the prescaler remainder at limits other than zero. The fourth is write-one-to-clear: writing zeros must leave a flag set. The fifth is the edge-mode variants. An edge detector that ignores the selected input, or that treats a falling edge as a rising one, would give counts other than 3 or 6 for three input pulses.

// File: rtl/tmr_pkg.sv
// Shared encodings and register addresses for the match timer.
// Assumes a 5-bit register address space.
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_CLK  = 2'd0,
        MODE_RISE = 2'd1,
        MODE_FALL = 2'd2,
        MODE_BOTH = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } tmr_act_e;

    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] A_CTRL    = 5'd0;
    localparam logic [REG_AW-1:0] A_LIMIT   = 5'd1;
    localparam logic [REG_AW-1:0] A_MODE    = 5'd2;
    localparam logic [REG_AW-1:0] A_MCTRL   = 5'd3;
    localparam logic [REG_AW-1:0] A_FLAGS   = 5'd4;
    localparam logic [REG_AW-1:0] A_ACTION  = 5'd5;
    localparam logic [REG_AW-1:0] A_LEVEL   = 5'd6;
    localparam logic [REG_AW-1:0] A_RELOAD  = 5'd7;
    localparam logic [REG_AW-1:0] A_TCOUNT  = 5'd8;
    localparam logic [REG_AW-1:0] A_PCOUNT  = 5'd9;
    localparam logic [REG_AW-1:0] A_CMP0    = 5'd16;
    localparam logic [REG_AW-1:0] A_SHD0    = 5'd24;

endpackage

// File: rtl/tmr_event_src.sv
// Event source: synchronizes the external inputs, picks one of them and
// turns the selected edges into single-cycle count events.
// In clock mode every cycle is an event.
// Assumes N_IN >= 2. A change of the selection may produce one edge.
module tmr_event_src
    import tmr_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int SEL_W = $clog2(N_IN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  cnt_in,
    input  tmr_mode_e        mode,
    input  logic [SEL_W-1:0] sel,
    output logic             evt
);

    logic [N_IN-1:0] sync1_q, sync2_q;
    logic            prev_q;
    logic            lvl;

    // Two-stage synchronizer per input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= cnt_in;
            sync2_q <= sync1_q;
        end
    end

    assign lvl = sync2_q[sel];

    // Previous level of the selected input for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // Event qualification by mode.
    always_comb begin
        unique case (mode)
            MODE_CLK:  evt = 1'b1;
            MODE_RISE: evt = lvl & ~prev_q;
            MODE_FALL: evt = ~lvl & prev_q;
            default:   evt = lvl ^ prev_q;
        endcase
    end

    assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RISE && evt) |=> !evt);

endmodule

// File: rtl/tmr_count_core.sv
// Prescaler and timer counter. adv marks an event that wraps the prescaler
// while running. Restart and halt requests arrive combinationally from the
// compare channels in the same cycle as adv.
module tmr_count_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             evt,
    input  logic [CNT_W-1:0] limit,
    input  logic             hit_rst,
    input  logic             hit_stop,
    output logic             adv,
    output logic [CNT_W-1:0] tc,
    output logic [CNT_W-1:0] pc
);

    logic [CNT_W-1:0] tc_q, pc_q;

    assign adv = run && !clr && evt && (pc_q >= limit);
    assign tc  = tc_q;
    assign pc  = pc_q;

    // Prescale counter: wraps at the limit, cleared by the counter reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)     pc_q <= '0;
        else if (run && evt)   pc_q <= (pc_q >= limit) ? '0 : pc_q + 1'b1;
    end

    // Timer counter: steps on adv, restarts or holds on a compare hit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)     tc_q <= '0;
        else if (adv) begin
            if (hit_rst)       tc_q <= '0;
            else if (!hit_stop) tc_q <= tc_q + 1'b1;
        end
    end

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(tc_q));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (tc_q == '0 && pc_q == '0));

    assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !hit_rst && !hit_stop) |=>
            (tc_q == $past(tc_q) || tc_q == CNT_W'($past(tc_q) + 1'b1)));

endmodule

// File: rtl/tmr_match_chan.sv
// One compare channel: compare value with shadow reload, hit detection,
// interrupt flag and external output level.
// Software writes of compare values take priority over a reload in the
// same cycle. Hardware actions take priority over software level writes.
module tmr_match_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [CNT_W-1:0] tc,
    input  logic             wr_cmp,
    input  logic             wr_shd,
    input  logic [CNT_W-1:0] wdata,
    input  logic             reload,
    input  tmr_act_e         act,
    input  logic             ie,
    input  logic             lvl_wr,
    input  logic             lvl_val,
    input  logic             flag_clr,
    output logic             hit,
    output logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] shd,
    output logic             out,
    output logic             flag
);

    logic [CNT_W-1:0] cmp_q, shd_q;
    logic             out_q, flag_q;

    assign hit  = adv && (tc == cmp_q);
    assign cmp  = cmp_q;
    assign shd  = shd_q;
    assign out  = out_q;
    assign flag = flag_q;

    // Compare value: software write, else shadow reload.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (wr_cmp) cmp_q <= wdata;
        else if (reload) cmp_q <= shd_q;
    end

    // Shadow value: software write only.
    always_ff @(posedge clk) begin
        if (!rst_n)      shd_q <= '0;
        else if (wr_shd) shd_q <= wdata;
    end

    // Interrupt flag: set by an enabled hit, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (hit && ie)  flag_q <= 1'b1;
        else if (flag_clr)   flag_q <= 1'b0;
    end

    // Output level: hit action first, then direct software write.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else if (hit && act != ACT_KEEP) begin
            unique case (act)
                ACT_LOW:  out_q <= 1'b0;
                ACT_HIGH: out_q <= 1'b1;
                default:  out_q <= ~out_q;
            endcase
        end else if (lvl_wr) out_q <= lvl_val;
    end

    assert_flag_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(hit && ie));

    assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_TOGGLE) |=> (out_q != $past(out_q)));

    assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !wr_cmp) |=> (cmp_q == $past(shd_q)));

endmodule

// File: rtl/match_timer.sv
// Top of the match timer: register file, read mux, event source,
// counter core and compare channels. A halt hit wins over a software
// write of the run enable in the same cycle.
module match_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int N_CH  = 4,
    parameter int N_IN  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [4:0]        rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic [N_IN-1:0]   cnt_in,
    output logic [N_CH-1:0]   match_out,
    output logic              irq
);

    localparam int SEL_W = $clog2(N_IN);
    localparam int MC_W  = 3 * N_CH;
    localparam int ACT_W = 2 * N_CH;

    logic              en_q, clr_q;
    logic [CNT_W-1:0]  limit_q;
    tmr_mode_e         mode_q;
    logic [SEL_W-1:0]  sel_q;
    logic [MC_W-1:0]   mctrl_q;
    logic [ACT_W-1:0]  act_q;
    logic [N_CH-1:0]   rld_q;

    logic              evt, adv;
    logic [CNT_W-1:0]  tc, pc;
    logic [N_CH-1:0]   hit, rst_bit, stop_bit, flag;
    logic              rst_any, stop_any;
    logic [CNT_W-1:0]  cmp_v [N_CH];
    logic [CNT_W-1:0]  shd_v [N_CH];

    function automatic logic wr_at(input logic [4:0] a);
        return wr_en && (wr_addr == a);
    endfunction

    // Configuration registers; a halt hit clears the run enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            clr_q   <= 1'b0;
            limit_q <= '0;
            mode_q  <= MODE_CLK;
            sel_q   <= '0;
            mctrl_q <= '0;
            act_q   <= '0;
            rld_q   <= '0;
        end else begin
            if (stop_any)          en_q <= 1'b0;
            else if (wr_at(A_CTRL)) en_q <= wr_data[0];
            if (wr_at(A_CTRL))   clr_q   <= wr_data[1];
            if (wr_at(A_LIMIT))  limit_q <= wr_data;
            if (wr_at(A_MODE)) begin
                mode_q <= tmr_mode_e'(wr_data[1:0]);
                sel_q  <= wr_data[2 +: SEL_W];
            end
            if (wr_at(A_MCTRL))  mctrl_q <= wr_data[MC_W-1:0];
            if (wr_at(A_ACTION)) act_q   <= wr_data[ACT_W-1:0];
            if (wr_at(A_RELOAD)) rld_q   <= wr_data[N_CH-1:0];
        end
    end

    tmr_event_src #(.N_IN(N_IN), .SEL_W(SEL_W)) u_src (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in),
        .mode(mode_q), .sel(sel_q), .evt(evt)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(en_q), .clr(clr_q), .evt(evt),
        .limit(limit_q), .hit_rst(rst_any), .hit_stop(stop_any),
        .adv(adv), .tc(tc), .pc(pc)
    );

    for (genvar n = 0; n < N_CH; n++) begin : g_ch
        localparam logic [4:0] CMP_A = A_CMP0 + 5'(n);
        localparam logic [4:0] SHD_A = A_SHD0 + 5'(n);
        assign rst_bit[n]  = mctrl_q[3*n+1];
        assign stop_bit[n] = mctrl_q[3*n+2];
        tmr_match_chan #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .adv(adv), .tc(tc),
            .wr_cmp(wr_at(CMP_A)), .wr_shd(wr_at(SHD_A)), .wdata(wr_data),
            .reload(rst_any && rld_q[n]),
            .act(tmr_act_e'(act_q[2*n +: 2])), .ie(mctrl_q[3*n]),
            .lvl_wr(wr_at(A_LEVEL)), .lvl_val(wr_data[n]),
            .flag_clr(wr_at(A_FLAGS) && wr_data[n]),
            .hit(hit[n]), .cmp(cmp_v[n]), .shd(shd_v[n]),
            .out(match_out[n]), .flag(flag[n])
        );
    end

    assign rst_any  = |(hit & rst_bit);
    assign stop_any = |(hit & stop_bit);
    assign irq      = |flag;

    // Combinational register read mux.
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:   rd_data = CNT_W'({clr_q, en_q});
            A_LIMIT:  rd_data = limit_q;
            A_MODE:   rd_data = CNT_W'({sel_q, mode_q});
            A_MCTRL:  rd_data = CNT_W'(mctrl_q);
            A_FLAGS:  rd_data = CNT_W'(flag);
            A_ACTION: rd_data = CNT_W'(act_q);
            A_LEVEL:  rd_data = CNT_W'(match_out);
            A_RELOAD: rd_data = CNT_W'(rld_q);
            A_TCOUNT: rd_data = tc;
            A_PCOUNT: rd_data = pc;
            default: begin
                for (int n = 0; n < N_CH; n++) begin
                    if (rd_addr == A_CMP0 + 5'(n)) rd_data = cmp_v[n];
                    if (rd_addr == A_SHD0 + 5'(n)) rd_data = shd_v[n];
                end
            end
        endcase
    end

    assert_halt_clears_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_any |=> !en_q);

    assert_irq_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag == '0) |-> !irq);

endmodule

// File: tb/tb_match_timer.sv
module tb_match_timer;
    import tmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  cnt_in = '0;
    logic [3:0]  match_out;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    match_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt_in(cnt_in), .match_out(match_out), .irq(irq)
    );

    // Vector fields: {limit, events, expected timer, expected prescaler}
    localparam int NV = 5;
    localparam logic [63:0] VEC [NV] = '{
        {16'd0, 16'd10, 16'd10, 16'd0},
        {16'd1, 16'd10, 16'd5,  16'd0},
        {16'd3, 16'd10, 16'd2,  16'd2},
        {16'd2, 16'd9,  16'd3,  16'd0},
        {16'd4, 16'd7,  16'd1,  16'd2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; commits on the next rising edge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic clear_counter();
        wr(A_CTRL, 32'h2);
        wr(A_CTRL, 32'h0);
    endtask

    // Enable, let n rising edges count, disable.
    task automatic run_events(input int n);
        wr(A_CTRL, 32'h1);
        repeat (n - 1) @(negedge clk);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic pulses(input int idx, input int k);
        for (int i = 0; i < k; i++) begin
            cnt_in[idx] = 1'b1;
            repeat (4) @(negedge clk);
            cnt_in[idx] = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic edge_run(input logic [1:0] md, input int idx, input logic [31:0] exp, input string req);
        logic [31:0] v;
        clear_counter();
        wr(A_MODE, {28'd0, 2'd2, md});
        wr(A_CTRL, 32'h1);
        pulses(idx, 3);
        repeat (6) @(negedge clk);
        wr(A_CTRL, 32'h0);
        rd(A_TCOUNT, v); chk(req, v, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R3, R7, R8)
        rd(A_TCOUNT, v); chk("R3 reset timer", v, 0);
        rd(A_CTRL, v);   chk("R3 reset control", v, 0);
        chk("R8 reset outputs", {28'd0, match_out}, 0);
        chk("R7 reset irq", {31'd0, irq}, 0);

        // Enable off: no counting (R3)
        repeat (5) @(negedge clk);
        rd(A_TCOUNT, v); chk("R3 idle hold", v, 0);

        // Prescale vector walk (R1)
        for (int i = 0; i < NV; i++) begin
            clear_counter();
            wr(A_LIMIT, {16'd0, VEC[i][63:48]});
            run_events(int'(VEC[i][47:32]));
            rd(A_TCOUNT, v); chk("R1 timer count", v, {16'd0, VEC[i][31:16]});
            rd(A_PCOUNT, v); chk("R1 prescale count", v, {16'd0, VEC[i][15:0]});
        end

        // Counter reset bit clears both counters (R3)
        clear_counter();
        rd(A_TCOUNT, v); chk("R3 clear timer", v, 0);
        rd(A_PCOUNT, v); chk("R3 clear prescaler", v, 0);
        wr(A_LIMIT, 0);

        // Restart + interrupt + toggle on channel 0 at compare 4 (R4, R5, R7, R8)
        wr(A_CMP0, 4);
        wr(A_MCTRL, 32'b011);
        wr(A_ACTION, 32'h3);
        clear_counter();
        run_events(5);
        rd(A_TCOUNT, v); chk("R5 restart to zero", v, 0);
        rd(A_FLAGS, v);  chk("R7 flag set", v, 1);
        chk("R7 irq high", {31'd0, irq}, 1);
        chk("R8 toggle", {28'd0, match_out}, 4'b0001);
        wr(A_FLAGS, 0);
        rd(A_FLAGS, v);  chk("R7 write zero keeps flag", v, 1);
        wr(A_FLAGS, 1);
        rd(A_FLAGS, v);  chk("R7 write one clears", v, 0);
        chk("R7 irq low", {31'd0, irq}, 0);

        // Halt on channel 1 at compare 3, drive high (R6, R8, R4)
        wr(A_CMP0 + 5'd1, 3);
        wr(A_MCTRL, 32'h1 << 5);
        wr(A_ACTION, 32'h2 << 2);
        clear_counter();
        wr(A_CTRL, 32'h1);
        repeat (10) @(negedge clk);
        rd(A_TCOUNT, v); chk("R6 halt holds value", v, 3);
        rd(A_CTRL, v);   chk("R6 enable cleared", v, 0);
        chk("R8 drive high", {28'd0, match_out}, 4'b0011);
        rd(A_FLAGS, v);  chk("R4 no flag without interrupt bit", v, 0);

        // Shadow reload on channel 2 (R9)
        wr(A_CMP0 + 5'd2, 2);
        wr(A_SHD0 + 5'd2, 6);
        wr(A_RELOAD, 32'b0100);
        wr(A_MCTRL, 32'h1 << 7);
        wr(A_ACTION, 32'h3 << 4);
        clear_counter();
        run_events(3);
        rd(A_TCOUNT, v);          chk("R9 restart by channel 2", v, 0);
        rd(A_CMP0 + 5'd2, v);     chk("R9 compare reloaded", v, 6);
        chk("R8 toggle ch2", {28'd0, match_out}, 4'b0111);

        // Direct levels and drive-low action (R8)
        wr(A_LEVEL, 32'b1010);
        rd(A_LEVEL, v); chk("R8 level readback", v, 4'b1010);
        wr(A_RELOAD, 0);
        wr(A_MCTRL, 0);
        wr(A_CMP0 + 5'd1, 1);
        wr(A_ACTION, 32'h1 << 2);
        clear_counter();
        run_events(2);
        rd(A_TCOUNT, v); chk("R8 count during low action", v, 2);
        chk("R8 drive low", {28'd0, match_out}, 4'b1000);

        // Edge count modes on input 2 (R2)
        wr(A_ACTION, 0);
        edge_run(2'd1, 2, 3, "R2 rising edges");
        edge_run(2'd2, 2, 3, "R2 falling edges");
        edge_run(2'd3, 2, 6, "R2 both edges");
        edge_run(2'd1, 0, 0, "R2 unselected input ignored");

        // Register map sanity (R10)
        rd(A_MODE, v); chk("R10 mode readback", v, 32'h9);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule